// File: doc/BRIEF.md
# Interval Timer and Time-of-Day Clock

This block keeps time from a single-cycle tick enable that arrives at 1024 Hz. It holds two counters that are presented together in one 64-bit word. The first is a 19-bit interval counter that counts down by one per tick and wraps around. The second is a 36-bit time-of-day counter that counts up. It is split into a 10-bit sub-second field and a 26-bit seconds field, and the seconds field advances once for every 1024 ticks.

When a tick takes the interval counter from one to zero, a sticky alarm flag is raised for the interrupt logic. Software lowers the flag with a clear strobe. Software can also load either counter at any time through its own load strobe and value. Word bit numbering runs from bit 0 as the most significant bit (`word_o[63]`) to bit 63 as the least significant (`word_o[0]`).

Top module: `tmr_timebase`

## Requirements
- R1: After reset the interval counter, both time-of-day fields and the alarm flag are zero.
- R2: On a tick with no interval load, the interval counter (word bits 0..18, `word_o[63:45]`) decreases by exactly one.
- R3: A tick at interval value zero wraps it to 19'h7FFFF and does not raise the alarm flag.
- R4: A tick that takes the interval counter from 1 to 0 raises the alarm flag in the same update.
- R5: The alarm flag stays high until a clear strobe. A clear in the same cycle as a raising tick leaves the flag high.
- R6: An interval load takes `itv_val_i` in place of that cycle's tick. A load never raises the flag, including a load of zero.
- R7: On a tick with no clock load, the sub-second field (word bits 28..37, `word_o[35:26]`) increases by one modulo 1024.
- R8: The seconds field (word bits 38..63, `word_o[25:0]`) increases by one only on the tick that wraps the sub-second field from 1023 to 0. The full clock therefore returns to zero after 2^36 ticks.
- R9: A clock load writes `clk_val_i` into word bits 28..63 in place of that cycle's tick, with `clk_val_i[35:26]` as sub-second and `clk_val_i[25:0]` as seconds.
- R10: Word bits 19..27 (`word_o[44:36]`) always read as zero.
- R11: In a cycle with no tick and no load, neither counter changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle 1024 Hz time step enable |
| itv_ld_i | input | 1 | Load strobe for the interval counter |
| itv_val_i | input | 19 | Interval load value |
| clk_ld_i | input | 1 | Load strobe for the time-of-day counter |
| clk_val_i | input | 36 | Time-of-day load value, sub-second in [35:26] |
| flag_clr_i | input | 1 | Clear strobe for the alarm flag |
| word_o | output | 64 | Packed word: interval, zero pad, time-of-day |
| flag_o | output | 1 | Sticky alarm flag |

## Verification
The assertions take it that every strobe is a clean synchronous level sampled once per clock. They also take it that the load values are fully defined whenever their strobe is high, so a load cycle is fully determined by the value on the bus. The random stimulus drives every input at the falling edge from a fixed-seed generator and keeps loads rare. It keeps interval load values mostly below four, so that zero crossings and wraps happen often. It loads sub-second values near 1023 so that seconds carries are reached within a few ticks.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned ITV_W  = 19;
  localparam int unsigned SUB_W  = 10;
  localparam int unsigned SEC_W  = 26;
  localparam int unsigned WORD_W = 64;
endpackage

// File: rtl/tmr_down_cnt.sv
module tmr_down_cnt #(
  parameter int unsigned W = 19
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  output logic [W-1:0] cnt_o,
  output logic         hit_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (ld_i)    cnt_q <= ld_val_i;
    else if (tick_i)  cnt_q <= cnt_q - ONE;
  end

  // only a tick-driven transition into zero counts
  assign hit_o = tick_i && !ld_i && (cnt_q == ONE);
  assign cnt_o = cnt_q;

  assert_dec_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !ld_i |=> cnt_q == $past(cnt_q) - ONE);
  assert_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !ld_i && cnt_q == '0 |=> cnt_q == '1);
  assert_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> cnt_q == $past(ld_val_i));
  assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !ld_i |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_up_cnt.sv
module tmr_up_cnt #(
  parameter int unsigned W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (ld_i)   cnt_q <= ld_val_i;
    else if (inc_i)  cnt_q <= cnt_q + W'(1);
  end

  assign wrap_o = inc_i && !ld_i && (&cnt_q);
  assign cnt_o  = cnt_q;

  assert_inc_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && !ld_i |=> cnt_q == $past(cnt_q) + W'(1));
  assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i && !ld_i |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_flag.sv
module tmr_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;  // set beats clear
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  assert_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_q);
  assert_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q && !clr_i |=> flag_q);
  assert_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_q && !set_i |=> !flag_q);
endmodule

// File: rtl/tmr_timebase.sv
module tmr_timebase
  import tmr_pkg::*;
#(
  parameter int unsigned IW = ITV_W,
  parameter int unsigned SW = SUB_W,
  parameter int unsigned CW = SEC_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                itv_ld_i,
  input  logic [IW-1:0]       itv_val_i,
  input  logic                clk_ld_i,
  input  logic [SW+CW-1:0]    clk_val_i,
  input  logic                flag_clr_i,
  output logic [WORD_W-1:0]   word_o,
  output logic                flag_o
);
  localparam int unsigned TW  = SW + CW;
  localparam int unsigned PAD = WORD_W - IW - TW;

  logic [IW-1:0] itv_cnt;
  logic          itv_hit;
  logic [SW-1:0] sub_cnt;
  logic [CW-1:0] sec_cnt;
  logic          sub_wrap;
  logic          sec_wrap;

  tmr_down_cnt #(.W(IW)) u_itv (
    .clk_i, .rst_ni,
    .tick_i   (tick_i),
    .ld_i     (itv_ld_i),
    .ld_val_i (itv_val_i),
    .cnt_o    (itv_cnt),
    .hit_o    (itv_hit)
  );

  tmr_up_cnt #(.W(SW)) u_sub (
    .clk_i, .rst_ni,
    .inc_i    (tick_i),
    .ld_i     (clk_ld_i),
    .ld_val_i (clk_val_i[TW-1:CW]),
    .cnt_o    (sub_cnt),
    .wrap_o   (sub_wrap)
  );

  tmr_up_cnt #(.W(CW)) u_sec (
    .clk_i, .rst_ni,
    .inc_i    (sub_wrap),
    .ld_i     (clk_ld_i),
    .ld_val_i (clk_val_i[CW-1:0]),
    .cnt_o    (sec_cnt),
    .wrap_o   (sec_wrap)
  );

  tmr_flag u_flag (
    .clk_i, .rst_ni,
    .set_i  (itv_hit),
    .clr_i  (flag_clr_i),
    .flag_o (flag_o)
  );

  assign word_o = {itv_cnt, {PAD{1'b0}}, sub_cnt, sec_cnt};

  assert_carry_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !clk_ld_i && (&sub_cnt) |=> sub_cnt == '0 && sec_cnt == $past(sec_cnt) + CW'(1));
  assert_nocarry_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_ld_i && !(tick_i && (&sub_cnt)) |=> $stable(sec_cnt));
  assert_rollover_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_wrap |=> sec_cnt == '0 && sub_cnt == '0);
  assert_clkld_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_ld_i |=> {sub_cnt, sec_cnt} == $past(clk_val_i));
  assert_ldnoflag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    itv_ld_i && !flag_o |=> !flag_o);
  assert_zeroflag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(|itv_cnt) && !$past(itv_ld_i) |-> flag_o);
endmodule

// File: tb/sim_tmr_timebase.sv
module sim_tmr_timebase;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        itv_ld_i = 1'b0;
  logic [18:0] itv_val_i = '0;
  logic        clk_ld_i = 1'b0;
  logic [35:0] clk_val_i = '0;
  logic        flag_clr_i = 1'b0;
  logic [63:0] word_o;
  logic        flag_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  logic [18:0] m_itv;
  logic [35:0] m_clk;
  logic        m_flag;

  always #4 clk_i = ~clk_i;

  tmr_timebase u0 (.*);

  function automatic logic [35:0] clk_next(logic [35:0] c);
    logic [9:0]  s = c[35:26];
    logic [25:0] q = c[25:0];
    if (s == 10'd1023) q = q + 26'd1;
    s = s + 10'd1;
    return {s, q};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // drive at negedge, update model, compare at next negedge
  task automatic step(logic tk, logic li, logic [18:0] iv, logic lc, logic [35:0] cv, logic cl);
    string ri, rc;
    tick_i = tk; itv_ld_i = li; itv_val_i = iv; clk_ld_i = lc; clk_val_i = cv; flag_clr_i = cl;
    ri = li ? "R6" : (tk ? (m_itv == 0 ? "R3" : "R2") : "R11");
    rc = lc ? "R9" : (tk ? (m_clk[35:26] == 10'd1023 ? "R8" : "R7") : "R11");
    if (li) m_itv = iv;
    else if (tk) begin
      if (m_itv == 19'd1) m_flag = 1'b1;
      else if (cl) m_flag = 1'b0;
      m_itv = m_itv - 19'd1;
    end
    if (!(tk && !li && m_itv == 19'd0 && !(li)) || li) ;
    if ((li || !tk) && cl) m_flag = 1'b0;
    if (lc) m_clk = cv;
    else if (tk) m_clk = clk_next(m_clk);
    @(posedge clk_i);
    @(negedge clk_i);
    chk(ri, 64'(word_o[63:45]), 64'(m_itv));
    chk(rc, 64'(word_o[35:0]), 64'(m_clk));
    chk("R5", 64'(flag_o), 64'(m_flag));
    chk("R10", 64'(word_o[44:36]), 64'd0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_vec++; n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1024_0bad));
    m_itv = '0; m_clk = '0; m_flag = 1'b0;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1", word_o, 64'd0);
    chk("R1", 64'(flag_o), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R3 wrap from zero, no flag
    step(1, 0, 0, 0, 0, 0);
    chk("R3", 64'(word_o[63:45]), 64'h7FFFF);
    chk("R3", 64'(flag_o), 64'd0);
    // R6 load 0 then load 1, no flag
    step(1, 1, 19'd0, 0, 0, 0);
    chk("R6", 64'(flag_o), 64'd0);
    step(0, 1, 19'd1, 0, 0, 0);
    // R4 tick 1->0 raises flag, clear in same cycle loses (R5)
    step(1, 0, 0, 0, 0, 1);
    chk("R4", 64'(flag_o), 64'd1);
    step(0, 0, 0, 0, 0, 0);
    chk("R5", 64'(flag_o), 64'd1);
    step(0, 0, 0, 0, 0, 1);
    chk("R5", 64'(flag_o), 64'd0);
    // R8 carry into seconds
    step(0, 0, 0, 1, {10'd1023, 26'd5}, 0);
    step(1, 0, 0, 0, 0, 0);
    chk("R8", 64'(word_o[25:0]), 64'd6);
    chk("R8", 64'(word_o[35:26]), 64'd0);
    // R8 full rollover
    step(0, 0, 0, 1, '1, 0);
    step(1, 0, 0, 0, 0, 0);
    chk("R8", 64'(word_o[35:0]), 64'd0);
    // R9 load beats tick
    step(1, 0, 0, 1, 36'h123456789, 0);
    chk("R9", 64'(word_o[35:0]), 64'h123456789);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic tk, li, lc, cl;
      logic [18:0] iv;
      logic [35:0] cv;
      tk = ($urandom % 2) == 0;
      li = ($urandom % 16) == 0;
      lc = ($urandom % 24) == 0;
      cl = ($urandom % 8) == 0;
      iv = ($urandom % 4 != 0) ? 19'($urandom % 4) : 19'($urandom);
      cv = {10'(1020 + $urandom % 4), 26'($urandom)};
      step(tk, li, iv, lc, cv, cl);
    end
    finish_run();
  end
endmodule